// File: doc/BRIEF.md
# Compositor Chain Frame-Transition Sequencer

This block decides when each stage in a chain of image-compositing stages may begin a new frame. The stages sit in a line. Start events travel down the line, from the head toward the display end. Completion events travel back up the line, from the display end toward the head. A stage marked as master launches a frame once every stage reports that its buffers are filled. Each later stage then takes the start, passes it to its neighbour one cycle later, and enables its local input framebuffer to stream out pixels.

Once a stage has streamed its programmed pixel count, it waits for completion from the stage below it. The last stage in the chain takes completion from the output framebuffers. When a stage has both finished streaming and seen completion, it passes a one-cycle completion pulse upward. The master accepts no new frame until that pulse has come back through every stage.

Each stage keeps a count of the frames it has started. Each stage also keeps a sticky flag that records a start which arrived while the stage was still streaming.

Top module: `frame_seq_chain`

## Requirements
- R1: A synchronous active-high reset clears every stage. After reset, `stream_en`, `sof`, `eof` and `overrun` are all zero, and every field of `frame_cnt` is zero.
- R2: A stage whose `master_en` bit is 1 pulses its `sof` bit only when it is waiting for a frame and every `pipe_ready` bit is 1. While any `pipe_ready` bit is 0, it does not launch. More than one master bit may be set, and each master launches on its own.
- R3: Stage 0 has no upstream start. For i > 0, the start input of stage i is `sof[i-1]`. A non-master stage that is waiting for a frame pulses `sof[i]` for one cycle, exactly one cycle after the `sof[i-1]` pulse.
- R4: The `stream_en` bit of a stage is high for exactly N consecutive cycles, starting in the cycle of its `sof` pulse. N is the `pix_count` value sampled when the start is accepted. A `pix_count` of 0 gives N = 1.
- R5: The completion input of stage NUM_STAGES-1 is `out_done`. The completion input of each other stage i is `eof[i+1]`. A stage pulses `eof` for one cycle only after its stream has ended. If completion arrives while the stage is waiting, `eof` follows one cycle later. If completion arrived during the stream, it is held, and `eof` comes two cycles after the last `stream_en` cycle.
- R6: If no completion ever arrives, no stage pulses `eof`, and the master does not launch again, even with all `pipe_ready` bits high.
- R7: After its `eof` pulse, the master is waiting again. Its next `sof` comes at the earliest two cycles after its `eof`.
- R8: Field i of `frame_cnt` (bits i*CNT_W upward) increases by one for each start that stage i accepts.
- R9: A start that reaches a stage while its `stream_en` is high is not accepted. It does not restart or lengthen the stream and does not change the count. It sets that stage's `overrun` bit, which then stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| master_en | input | NUM_STAGES | Per-stage master flag |
| pipe_ready | input | NUM_STAGES | Per-stage buffers-filled indication |
| out_done | input | 1 | Completion pulse from the output framebuffers |
| pix_count | input | PIX_W | Pixels streamed per frame |
| stream_en | output | NUM_STAGES | Per-stage enable to the local input framebuffer |
| sof | output | NUM_STAGES | Per-stage start pulse sent downstream |
| eof | output | NUM_STAGES | Per-stage completion pulse sent upstream |
| frame_cnt | output | NUM_STAGES*CNT_W | Per-stage frame counters, packed |
| overrun | output | NUM_STAGES | Per-stage sticky late-start flag |

## Verification
The chain is run with several stream lengths: three pixels, two pixels, six pixels, and a count of zero. Each run shows that the stream window is measured per stage and that a zero count gives one cycle. Completion is sent in two ways. Sent after every stream has ended, it shows the plain one-cycle relay. Sent while the last stage is still streaming, it shows whether the held completion is kept or lost. Readiness is held low, partly low, or withheld together with completion, which tells whether the master is gated by readiness or by the return of completion. A run with two master bits set forces a start onto a stage that is already streaming, which brings out the overrun flag.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_READY,
    ST_STREAMING,
    ST_WAIT_FINISH,
    ST_RELAY
  } seq_state_e;

  // Effective stream length: a zero count still yields one pixel slot.
  function automatic int unsigned eff_len(input int unsigned pix);
    return (pix == 0) ? 1 : pix;
  endfunction

  // Wrapping frame count increment.
  function automatic int unsigned next_count(input int unsigned cnt, input int unsigned width);
    return (cnt + 1) & ((1 << width) - 1);
  endfunction

endpackage

// File: rtl/fseq_stream_ctr.sv
module fseq_stream_ctr #(
  parameter int PIX_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [PIX_W-1:0] pix_count,
  output logic             active,
  output logic             last
);
  import fseq_pkg::*;

  logic [PIX_W-1:0] len_q;
  logic [PIX_W-1:0] idx_q;

  assign last = active && (idx_q == len_q - PIX_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      len_q  <= '0;
      idx_q  <= '0;
    end else if (load) begin
      active <= 1'b1;
      len_q  <= PIX_W'(eff_len(32'(pix_count)));
      idx_q  <= '0;
    end else if (active) begin
      if (last) active <= 1'b0;
      else      idx_q  <= idx_q + PIX_W'(1);
    end
  end

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    active |-> (idx_q < len_q)); // R4

  AST_LOAD_STARTS_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    load |=> (active && idx_q == '0)); // R4

endmodule

// File: rtl/fseq_stage.sv
module fseq_stage #(
  parameter int PIX_W = 12,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             is_master,
  input  logic             all_ready,
  input  logic             start_in,
  input  logic             finish_in,
  input  logic [PIX_W-1:0] pix_count,
  output logic             sof_o,
  output logic             eof_o,
  output logic             stream_en,
  output logic [CNT_W-1:0] frame_cnt,
  output logic             overrun
);
  import fseq_pkg::*;

  seq_state_e state_q;
  seq_state_e state_d;

  // Named internal events for the assertions.
  logic take_start;
  logic late_start;
  logic fin_seen_q;
  logic fin_hit;
  logic strm_active;
  logic strm_last;

  assign take_start = (state_q == ST_WAIT_READY) && (is_master ? all_ready : start_in);
  assign late_start = start_in && (state_q == ST_STREAMING);
  assign fin_hit    = finish_in || fin_seen_q;
  assign stream_en  = (state_q == ST_STREAMING);
  assign eof_o      = (state_q == ST_RELAY);

  fseq_stream_ctr #(.PIX_W(PIX_W)) u_ctr (
    .clk       (clk),
    .rst       (rst),
    .load      (take_start),
    .pix_count (pix_count),
    .active    (strm_active),
    .last      (strm_last)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:        state_d = ST_WAIT_READY;
      ST_WAIT_READY:  if (take_start) state_d = ST_STREAMING;
      ST_STREAMING:   if (strm_last)  state_d = ST_WAIT_FINISH;
      ST_WAIT_FINISH: if (fin_hit)    state_d = ST_RELAY;
      ST_RELAY:       state_d = ST_WAIT_READY;
      default:        state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      sof_o      <= 1'b0;
      fin_seen_q <= 1'b0;
      frame_cnt  <= '0;
      overrun    <= 1'b0;
    end else begin
      state_q <= state_d;
      sof_o   <= take_start;
      if (take_start || (state_q == ST_WAIT_FINISH && fin_hit))
        fin_seen_q <= 1'b0;
      else if (finish_in)
        fin_seen_q <= 1'b1;
      if (take_start)
        frame_cnt <= CNT_W'(next_count(32'(frame_cnt), CNT_W));
      if (late_start)
        overrun <= 1'b1;
    end
  end

  AST_SOF_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    sof_o |=> !sof_o); // R3

  AST_STREAM_OPENS_WITH_SOF: assert property (@(posedge clk) disable iff (rst)
    $rose(stream_en) |-> sof_o); // R4

  AST_STATE_MATCHES_CTR: assert property (@(posedge clk) disable iff (rst)
    stream_en == strm_active); // R4

  AST_MASTER_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
    (sof_o && is_master) |-> $past(all_ready)); // R2

  AST_FORWARD_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (!is_master && start_in && state_q == ST_WAIT_READY) |=> sof_o); // R3

  AST_EOF_NEEDS_FINISH: assert property (@(posedge clk) disable iff (rst)
    eof_o |-> $past(fin_hit)); // R5

  AST_EOF_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    eof_o |=> !eof_o); // R5

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    sof_o |-> (frame_cnt == CNT_W'($past(frame_cnt) + 1'b1))); // R8

  AST_LATE_START_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    (start_in && stream_en) |=> (overrun && frame_cnt == $past(frame_cnt))); // R9

  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun); // R9

endmodule

// File: rtl/frame_seq_chain.sv
module frame_seq_chain #(
  parameter int NUM_STAGES = 3,
  parameter int PIX_W      = 12,
  parameter int CNT_W      = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_STAGES-1:0]       master_en,
  input  logic [NUM_STAGES-1:0]       pipe_ready,
  input  logic                        out_done,
  input  logic [PIX_W-1:0]            pix_count,
  output logic [NUM_STAGES-1:0]       stream_en,
  output logic [NUM_STAGES-1:0]       sof,
  output logic [NUM_STAGES-1:0]       eof,
  output logic [NUM_STAGES*CNT_W-1:0] frame_cnt,
  output logic [NUM_STAGES-1:0]       overrun
);

  localparam int LAST = NUM_STAGES - 1;

  logic all_ready;
  logic [NUM_STAGES-1:0] start_link;
  logic [NUM_STAGES-1:0] finish_link;

  assign all_ready = &pipe_ready;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_head
        assign start_link[gi] = 1'b0;
      end else begin : g_body
        assign start_link[gi] = sof[gi-1];
      end
      if (gi == LAST) begin : g_tail
        assign finish_link[gi] = out_done;
      end else begin : g_inner
        assign finish_link[gi] = eof[gi+1];
      end

      fseq_stage #(.PIX_W(PIX_W), .CNT_W(CNT_W)) u_stage (
        .clk       (clk),
        .rst       (rst),
        .is_master (master_en[gi]),
        .all_ready (all_ready),
        .start_in  (start_link[gi]),
        .finish_in (finish_link[gi]),
        .pix_count (pix_count),
        .sof_o     (sof[gi]),
        .eof_o     (eof[gi]),
        .stream_en (stream_en[gi]),
        .frame_cnt (frame_cnt[gi*CNT_W +: CNT_W]),
        .overrun   (overrun[gi])
      );
    end
  endgenerate

  AST_NO_EOF_WHILE_STREAMING: assert property (@(posedge clk) disable iff (rst)
    ((eof & stream_en) == '0)); // R5

endmodule

// File: tb/frame_seq_chain_test.sv
`timescale 1ns/1ps
module frame_seq_chain_test;

  localparam int N  = 3;
  localparam int PW = 12;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst;
  logic [N-1:0] master_en;
  logic [N-1:0] pipe_ready;
  logic out_done;
  logic [PW-1:0] pix_count;
  logic [N-1:0] stream_en, sof, eof, overrun;
  logic [N*CW-1:0] frame_cnt;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int sof_c[N], sof_n[N], en_first[N], en_last[N], en_n[N], eof_c[N], eof_n[N];

  always #2 clk = ~clk;

  frame_seq_chain #(.NUM_STAGES(N), .PIX_W(PW), .CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .master_en(master_en), .pipe_ready(pipe_ready),
    .out_done(out_done), .pix_count(pix_count), .stream_en(stream_en),
    .sof(sof), .eof(eof), .frame_cnt(frame_cnt), .overrun(overrun)
  );

  always @(negedge clk) begin
    cyc++;
    for (int i = 0; i < N; i++) begin
      if (sof[i]) begin
        if (sof_n[i] == 0) sof_c[i] = cyc;
        sof_n[i]++;
      end
      if (stream_en[i]) begin
        if (en_n[i] == 0) en_first[i] = cyc;
        en_last[i] = cyc;
        en_n[i]++;
      end
      if (eof[i]) begin
        if (eof_n[i] == 0) eof_c[i] = cyc;
        eof_n[i]++;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic clear_log();
    for (int i = 0; i < N; i++) begin
      sof_c[i] = -1; sof_n[i] = 0; en_first[i] = -1; en_last[i] = -1;
      en_n[i] = 0; eof_c[i] = -1; eof_n[i] = 0;
    end
  endtask

  function automatic int cnt_of(input int i);
    return int'(frame_cnt[i*CW +: CW]);
  endfunction

  task automatic do_reset(input logic [N-1:0] m);
    rst = 1'b1; master_en = m; pipe_ready = '0; out_done = 1'b0;
    repeat (3) step();
    rst = 1'b0;
    step();
  endtask

  task automatic launch();
    clear_log();
    pipe_ready = '1;
    step();
    pipe_ready = '0;
  endtask

  task automatic finish_frame(output int d);
    out_done = 1'b1;
    d = cyc;
    step();
    out_done = 1'b0;
    repeat (8) step();
  endtask

  task automatic t_reset();
    rst = 1'b1; master_en = 3'b001; pipe_ready = '0; out_done = 1'b0; pix_count = 12'd3;
    repeat (4) step();
    chk("R1 stream_en in reset", int'(stream_en), 0);
    chk("R1 sof in reset", int'(sof), 0);
    chk("R1 eof in reset", int'(eof), 0);
    chk("R1 overrun in reset", int'(overrun), 0);
    chk("R1 frame_cnt in reset", int'(frame_cnt), 0);
    rst = 1'b0;
    step();
  endtask

  task automatic t_hold();
    clear_log();
    pipe_ready = 3'b110;
    repeat (15) step();
    chk("R2 no launch with partial ready", sof_n[0], 0);
    chk("R2 no streaming with partial ready", en_n[0] + en_n[1] + en_n[2], 0);
    pipe_ready = '0;
  endtask

  task automatic t_basic();
    int d;
    pix_count = 12'd3;
    launch();
    repeat (12) step();
    for (int i = 0; i < N; i++) begin
      chk("R4 stream length pix=3", en_n[i], 3);
      chk("R4 stream contiguous", en_last[i] - en_first[i] + 1, 3);
      chk("R4 stream opens with sof", en_first[i], sof_c[i]);
      chk("R3 sof spacing", sof_c[i], sof_c[0] + i);
      chk("R6 no eof without completion", eof_n[i], 0);
    end
    pipe_ready = '1;
    repeat (10) step();
    chk("R6 no relaunch without completion", sof_n[0], 1);
    pipe_ready = '0;
    finish_frame(d);
    chk("R5 tail eof after out_done", eof_c[2], d + 1);
    chk("R5 middle eof relayed", eof_c[1], d + 2);
    chk("R5 head eof relayed", eof_c[0], d + 3);
    for (int i = 0; i < N; i++) begin
      chk("R5 single eof pulse", eof_n[i], 1);
      chk("R8 frame count after first frame", cnt_of(i), 1);
    end
    chk("R2 no relaunch while not ready", sof_n[0], 1);
  endtask

  task automatic t_restart();
    int d;
    pix_count = 12'd2;
    launch();
    repeat (10) step();
    clear_log();
    pipe_ready = '1;
    finish_frame(d);
    pipe_ready = '0;
    chk("R7 master relaunch two cycles after eof", sof_c[0], eof_c[0] + 2);
    chk("R7 relaunch cycle", sof_c[0], d + 5);
    chk("R3 relaunch reaches tail", sof_c[2], d + 7);
    repeat (6) step();
    for (int i = 0; i < N; i++)
      chk("R8 frame count after three frames", cnt_of(i), 3);
    finish_frame(d);
  endtask

  task automatic t_early();
    int d;
    pix_count = 12'd6;
    launch();
    repeat (3) step();
    finish_frame(d);
    repeat (14) step();
    chk("R4 stream length pix=6", en_n[2], 6);
    chk("R5 held completion waits for stream", eof_c[2], en_last[2] + 2);
    chk("R5 held completion relay mid", eof_c[1], eof_c[2] + 1);
    chk("R5 held completion relay head", eof_c[0], eof_c[2] + 2);
  endtask

  task automatic t_zero();
    int d;
    pix_count = 12'd0;
    launch();
    repeat (8) step();
    for (int i = 0; i < N; i++)
      chk("R4 zero count gives one cycle", en_n[i], 1);
    finish_frame(d);
  endtask

  task automatic t_overrun();
    int d;
    do_reset(3'b011);
    pix_count = 12'd4;
    launch();
    repeat (10) step();
    chk("R2 two masters launch together", sof_c[1], sof_c[0]);
    chk("R3 tail follows stage 1", sof_c[2], sof_c[1] + 1);
    chk("R9 overrun on late start", int'(overrun), 2);
    chk("R9 late start not counted", cnt_of(1), 1);
    chk("R9 late start does not lengthen", en_n[1], 4);
    finish_frame(d);
    chk("R9 overrun sticky", int'(overrun), 2);
    do_reset(3'b001);
    chk("R1 reset clears overrun", int'(overrun), 0);
    chk("R1 reset clears counts", int'(frame_cnt), 0);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", cyc, 200000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clear_log();
    t_reset();
    t_hold();
    t_basic();
    t_restart();
    t_early();
    t_zero();
    t_overrun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule